// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block guards the memory reserved for system management mode (SMM). It holds two configuration bytes, a main SMRAM control byte and an extended control byte. From them it works out which memory each access reaches: the legacy SMRAM window at 0xA0000–0xBFFFF, a high alias of that window at 0xFEDA0000, and a TSEG region cut from the top of low memory. A lock bit in the main control byte can only be set. Once set, it closes the open window and narrows which bits software may still change.

Each access presents an address and an SMM flag. One cycle later the block returns a routing select (DRAM, bus or sink), the address to use in DRAM, and the read data. For a sink the read data is all ones and any write is dropped. A 16-bit extended-size register supports a handshake. Software writes the query value 0xFFFF and reads back the configured TSEG size in MiB. The size of low memory and the extended TSEG size are parameters (`LOW_MEM_MB`, `EXT_MB`). `EXT_MB` is clamped to 4095.

Top module: `smram_guard`

## Requirements
- R1: After reset, the main control byte (register 0) reads 0x02, the extended control byte (register 1) reads 0x00, and the extended-size register (register 2) reads 0xFFFF when EXT_MB is non-zero. All view outputs read 0, tseg_mb reads 0 and tseg_base equals LOW_MEM_MB MiB.
- R2: Main control byte layout: bit 3 global enable, bit 4 lock, bit 5 close, bit 6 open, bits 2:0 read-only 3'b010. Before lock, bits 6:3 are writable. The lock bit can only be set, never cleared by a write. While lock is 1, open reads 0, including in the write that sets lock.
- R3: While locked, only bit 5 of the main control byte is writable. The extended control byte ignores all writes.
- R4: Extended control byte layout: bit 0 TSEG enable, bits 2:1 size code, bit 7 high enable. A non-SMM access to the legacy window goes to DRAM only when open=1 and high=0. Otherwise it goes to the bus.
- R5: A non-SMM access to 0xFEDA0000–0xFEDBFFFF goes to DRAM only when open=1 and high=1. The returned address is then remapped into the legacy window. Otherwise the access goes to the bus with its address unchanged.
- R6: An SMM access reaches the legacy window in DRAM when global=1 and high=0. It reaches the high alias when global=1 and high=1. Otherwise it falls back to the non-SMM view.
- R7: TSEG is active only when TSEG enable=1 and global=1. Size code 0, 1, 2 and 3 give 1, 2 and 8 MiB and EXT_MB respectively, reported on tseg_mb. tseg_mb is 0 when TSEG is inactive.
- R8: TSEG spans from (LOW_MEM_MB − size) MiB up to LOW_MEM_MB MiB, reported on tseg_base. Inside it, a non-SMM access is routed to the sink (code 2) with rsp_rdata all ones, and an SMM access goes to DRAM (code 0).
- R9: The extended-size register is written per byte lane. When the resulting value is 0xFFFF and EXT_MB is non-zero, it stores EXT_MB instead.
- R10: Every access with acc_valid gives exactly one rsp_valid pulse on the following clock edge.
- R11: Outside all windows, addresses below LOW_MEM_MB MiB go to DRAM (code 0) and all others go to the bus (code 1). rsp_rdata is 0 for every route except the sink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write target: 0 main, 1 extended, 2 extended size |
| cfg_be | input | 2 | Byte lane enables |
| cfg_wdata | input | 16 | Write data |
| cfg_raddr | input | 2 | Read select |
| cfg_rdata | output | 16 | Read data for cfg_raddr |
| acc_valid | input | 1 | Access request |
| acc_smm | input | 1 | Access issued in SMM |
| acc_addr | input | 32 | Access address |
| rsp_valid | output | 1 | Response valid |
| rsp_route | output | 2 | 0 DRAM, 1 bus, 2 sink |
| rsp_addr | output | 32 | Address after alias remap |
| rsp_rdata | output | 32 | Sink read data |
| legacy_ram_open | output | 1 | Non-SMM sees legacy DRAM |
| high_alias_open | output | 1 | Non-SMM sees high alias |
| smm_low_en | output | 1 | SMM sees legacy DRAM |
| smm_high_en | output | 1 | SMM sees high alias |
| tseg_active | output | 1 | TSEG region enabled |
| tseg_mb | output | 12 | TSEG size in MiB |
| tseg_base | output | 32 | TSEG base byte address |

## Verification
A configuration write takes effect at the clock edge that samples it. The read port, view outputs, tseg_mb and tseg_base are combinational from the registers, so they show the new value right after that edge. An access response is registered once and appears on the edge after the request. The bench drives all inputs at falling edges and checks results at the next falling edge, half a cycle after the edge that produced them. For responses, it also checks that rsp_valid has dropped one cycle later.

// File: rtl/smg_pkg.sv
package smg_pkg;
    localparam int unsigned ADDR_W        = 32;
    localparam int unsigned MB_SHIFT      = 20;
    localparam int unsigned EXT_MB_LIMIT  = 4095;

    localparam logic [1:0]  CFG_CTL = 2'd0;
    localparam logic [1:0]  CFG_EXT = 2'd1;
    localparam logic [1:0]  CFG_XSZ = 2'd2;

    localparam logic [7:0]  CTL_RESET     = 8'h02;
    localparam logic [7:0]  CTL_MASK_OPEN = 8'h78;
    localparam logic [7:0]  CTL_MASK_LOCK = 8'h20;
    localparam logic [7:0]  EXT_MASK_OPEN = 8'h87;
    localparam logic [7:0]  EXT_MASK_LOCK = 8'h00;
    localparam logic [15:0] SIZE_QUERY    = 16'hFFFF;

    localparam logic [ADDR_W-1:0] LEG_BASE = 32'h000A_0000;
    localparam logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000;
    localparam logic [ADDR_W-1:0] HI_BASE  = 32'hFEDA_0000;

    typedef enum logic [1:0] {
        RT_DRAM = 2'd0,
        RT_BUS  = 2'd1,
        RT_SINK = 2'd2
    } route_e;

    typedef struct packed {
        logic       rsvd;
        logic       open;
        logic       close;
        logic       lock;
        logic       glob;
        logic [2:0] seg;
    } smctl_t;

    typedef struct packed {
        logic       hi;
        logic [3:0] rsvd;
        logic [1:0] szc;
        logic       ten;
    } exctl_t;

    typedef struct packed {
        logic low_ram_nsmm;
        logic hi_ram_nsmm;
        logic smm_low;
        logic smm_high;
        logic tseg_on;
    } view_t;

    function automatic logic [11:0] tseg_size_mb(input logic [1:0] code,
                                                 input int unsigned ext_mb);
        case (code)
            2'd0:    return 12'd1;
            2'd1:    return 12'd2;
            2'd2:    return 12'd8;
            default: return 12'(ext_mb);
        endcase
    endfunction
endpackage

// File: rtl/smg_regs.sv
module smg_regs
    import smg_pkg::*;
#(
    parameter int unsigned EXT_MB = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    output smctl_t      ctl_q,
    output exctl_t      ext_q,
    output logic [15:0] xsz_q
);
    localparam logic [15:0] XSZ_RESET = (EXT_MB != 0) ? SIZE_QUERY : 16'h0000;

    smctl_t      ctl_d;
    exctl_t      ext_d;
    logic [15:0] xsz_d;
    logic [7:0]  cmask, emask;

    always_comb begin
        cmask = ctl_q.lock ? CTL_MASK_LOCK : CTL_MASK_OPEN;
        emask = ctl_q.lock ? EXT_MASK_LOCK : EXT_MASK_OPEN;
        ctl_d = ctl_q;
        ext_d = ext_q;
        xsz_d = xsz_q;
        if (we && be[0] && addr == CFG_CTL) begin
            ctl_d      = smctl_t'((ctl_q & ~cmask) | (wdata[7:0] & cmask));
            ctl_d.lock = ctl_d.lock | ctl_q.lock;
        end
        if (ctl_d.lock) begin
            ctl_d.open = 1'b0;
        end
        if (we && be[0] && addr == CFG_EXT) begin
            ext_d = exctl_t'((ext_q & ~emask) | (wdata[7:0] & emask));
        end
        if (we && addr == CFG_XSZ) begin
            if (be[0]) xsz_d[7:0]  = wdata[7:0];
            if (be[1]) xsz_d[15:8] = wdata[15:8];
            if (EXT_MB != 0 && xsz_d == SIZE_QUERY) begin
                xsz_d = 16'(EXT_MB);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= smctl_t'(CTL_RESET);
            ext_q <= exctl_t'(8'h00);
            xsz_q <= XSZ_RESET;
        end else begin
            ctl_q <= ctl_d;
            ext_q <= ext_d;
            xsz_q <= xsz_d;
        end
    end
endmodule

// File: rtl/smg_view.sv
module smg_view
    import smg_pkg::*;
#(
    parameter int unsigned LOW_MEM_MB = 2048,
    parameter int unsigned EXT_MB     = 16
) (
    input  logic        glob,
    input  logic        open,
    input  logic        hi,
    input  logic        ten,
    input  logic [1:0]  szc,
    output view_t       view,
    output logic [11:0] tseg_mb,
    output logic [12:0] tseg_base_mb
);
    localparam logic [12:0] LOW_MB = 13'(LOW_MEM_MB);

    always_comb begin
        view.low_ram_nsmm = open & ~hi;
        view.hi_ram_nsmm  = open & hi;
        view.smm_low      = glob & ~hi;
        view.smm_high     = glob & hi;
        view.tseg_on      = glob & ten;
        tseg_mb           = view.tseg_on ? tseg_size_mb(szc, EXT_MB) : 12'd0;
        tseg_base_mb      = ({1'b0, tseg_mb} >= LOW_MB) ? 13'd0
                                                        : LOW_MB - {1'b0, tseg_mb};
    end
endmodule

// File: rtl/smg_decode.sv
module smg_decode
    import smg_pkg::*;
#(
    parameter int unsigned LOW_MEM_MB = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  view_t             view,
    input  logic [12:0]       tseg_base_mb,
    input  logic              acc_valid,
    input  logic              acc_smm,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rsp_valid,
    output route_e            rsp_route,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [ADDR_W-1:0] rsp_rdata
);
    localparam logic [12:0] LOW_MB = 13'(LOW_MEM_MB);

    logic [12:0]       amb;
    logic              in_leg, in_hi, in_tseg, ram;
    route_e            route_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        amb     = {1'b0, acc_addr[ADDR_W-1:MB_SHIFT]};
        in_leg  = (acc_addr >= LEG_BASE) && (acc_addr < LEG_BASE + WIN_SIZE);
        in_hi   = (acc_addr >= HI_BASE) && (acc_addr < HI_BASE + WIN_SIZE);
        in_tseg = view.tseg_on && (amb >= tseg_base_mb) && (amb < LOW_MB);
        ram     = 1'b0;
        addr_d  = acc_addr;
        route_d = (amb < LOW_MB) ? RT_DRAM : RT_BUS;
        if (in_leg) begin
            ram     = view.low_ram_nsmm | (acc_smm & view.smm_low);
            route_d = ram ? RT_DRAM : RT_BUS;
        end else if (in_hi) begin
            ram     = view.hi_ram_nsmm | (acc_smm & view.smm_high);
            route_d = ram ? RT_DRAM : RT_BUS;
            if (ram) addr_d = acc_addr - HI_BASE + LEG_BASE;
        end else if (in_tseg) begin
            route_d = acc_smm ? RT_DRAM : RT_SINK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_route <= RT_BUS;
            rsp_addr  <= '0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            if (acc_valid) begin
                rsp_route <= route_d;
                rsp_addr  <= addr_d;
                rsp_rdata <= (route_d == RT_SINK) ? '1 : '0;
            end
        end
    end
endmodule

// File: rtl/smram_guard.sv
module smram_guard
    import smg_pkg::*;
#(
    parameter int unsigned LOW_MEM_MB = 2048,
    parameter int unsigned EXT_MB     = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [1:0]  cfg_be,
    input  logic [15:0] cfg_wdata,
    input  logic [1:0]  cfg_raddr,
    output logic [15:0] cfg_rdata,
    input  logic        acc_valid,
    input  logic        acc_smm,
    input  logic [31:0] acc_addr,
    output logic        rsp_valid,
    output logic [1:0]  rsp_route,
    output logic [31:0] rsp_addr,
    output logic [31:0] rsp_rdata,
    output logic        legacy_ram_open,
    output logic        high_alias_open,
    output logic        smm_low_en,
    output logic        smm_high_en,
    output logic        tseg_active,
    output logic [11:0] tseg_mb,
    output logic [31:0] tseg_base
);
    localparam int unsigned EXT_EFF = (EXT_MB > EXT_MB_LIMIT) ? EXT_MB_LIMIT : EXT_MB;

    smctl_t      ctl_q;
    exctl_t      ext_q;
    logic [15:0] xsz_q;
    view_t       view;
    logic [12:0] base_mb;
    route_e      route;

    smg_regs #(.EXT_MB(EXT_EFF)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .be(cfg_be),
        .wdata(cfg_wdata), .ctl_q(ctl_q), .ext_q(ext_q), .xsz_q(xsz_q)
    );

    smg_view #(.LOW_MEM_MB(LOW_MEM_MB), .EXT_MB(EXT_EFF)) u_view (
        .glob(ctl_q.glob), .open(ctl_q.open), .hi(ext_q.hi), .ten(ext_q.ten),
        .szc(ext_q.szc), .view(view), .tseg_mb(tseg_mb), .tseg_base_mb(base_mb)
    );

    smg_decode #(.LOW_MEM_MB(LOW_MEM_MB)) u_decode (
        .clk(clk), .rst(rst), .view(view), .tseg_base_mb(base_mb),
        .acc_valid(acc_valid), .acc_smm(acc_smm), .acc_addr(acc_addr),
        .rsp_valid(rsp_valid), .rsp_route(route), .rsp_addr(rsp_addr),
        .rsp_rdata(rsp_rdata)
    );

    always_comb begin
        case (cfg_raddr)
            CFG_CTL: cfg_rdata = {8'h00, ctl_q};
            CFG_EXT: cfg_rdata = {8'h00, ext_q};
            CFG_XSZ: cfg_rdata = xsz_q;
            default: cfg_rdata = 16'h0000;
        endcase
        rsp_route       = route;
        legacy_ram_open = view.low_ram_nsmm;
        high_alias_open = view.hi_ram_nsmm;
        smm_low_en      = view.smm_low;
        smm_high_en     = view.smm_high;
        tseg_active     = view.tseg_on;
        tseg_base       = 32'(base_mb) << MB_SHIFT;
    end
endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk
    import smg_pkg::*;
#(
    parameter int unsigned EXT_MB = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [1:0]  cfg_addr,
    input logic [1:0]  cfg_be,
    input smctl_t      ctl_q,
    input exctl_t      ext_q,
    input logic [15:0] xsz_q,
    input logic        acc_valid,
    input logic        rsp_valid,
    input logic [1:0]  rsp_route,
    input logic [31:0] rsp_rdata,
    input logic        legacy_ram_open,
    input logic        high_alias_open,
    input logic        smm_low_en,
    input logic        smm_high_en,
    input logic        tseg_active
);
    assert_lock_clears_open_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |-> !ctl_q.open);

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_q.lock) |-> ctl_q.lock);

    assert_ext_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_q.lock) |-> $stable(ext_q));

    assert_open_views_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(legacy_ram_open && high_alias_open));

    assert_smm_views_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({smm_low_en, smm_high_en}));

    assert_tseg_needs_global_R7: assert property (@(posedge clk) disable iff (rst)
        tseg_active |-> ctl_q.glob);

    assert_sink_all_ones_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == RT_SINK) |-> (&rsp_rdata));

    assert_query_resolved_R9: assert property (@(posedge clk) disable iff (rst)
        (EXT_MB != 0 && cfg_we && cfg_addr == CFG_XSZ && cfg_be == 2'b11)
        |=> (xsz_q != SIZE_QUERY));

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);
endmodule

bind smram_guard smram_guard_chk #(.EXT_MB(EXT_EFF)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .ctl_q(ctl_q), .ext_q(ext_q), .xsz_q(xsz_q), .acc_valid(acc_valid),
    .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_rdata(rsp_rdata),
    .legacy_ram_open(legacy_ram_open), .high_alias_open(high_alias_open),
    .smm_low_en(smm_low_en), .smm_high_en(smm_high_en), .tseg_active(tseg_active)
);

// File: tb/smram_guard_bench.sv
module smram_guard_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  cfg_raddr = '0;
    logic [15:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_smm = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_route;
    logic [31:0] rsp_addr, rsp_rdata;
    logic        legacy_ram_open, high_alias_open, smm_low_en, smm_high_en, tseg_active;
    logic [11:0] tseg_mb;
    logic [31:0] tseg_base;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smram_guard u_smram_guard (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_smm(acc_smm), .acc_addr(acc_addr),
        .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_addr(rsp_addr),
        .rsp_rdata(rsp_rdata), .legacy_ram_open(legacy_ram_open),
        .high_alias_open(high_alias_open), .smm_low_en(smm_low_en),
        .smm_high_en(smm_high_en), .tseg_active(tseg_active), .tseg_mb(tseg_mb),
        .tseg_base(tseg_base)
    );

    // {ctl, ext, smm, addr, route, out_addr}; route 0 DRAM, 1 bus, 2 sink
    localparam int NV = 18;
    localparam logic [82:0] VEC [NV] = '{
        {8'h02, 8'h00, 1'b0, 32'h000A_0000, 2'd1, 32'h000A_0000},  // R4 closed
        {8'h42, 8'h00, 1'b0, 32'h000A_0000, 2'd0, 32'h000A_0000},  // R4 open low
        {8'h42, 8'h80, 1'b0, 32'h000A_1000, 2'd1, 32'h000A_1000},  // R4 open high
        {8'h42, 8'h80, 1'b0, 32'hFEDA_1234, 2'd0, 32'h000A_1234},  // R5 alias open
        {8'h02, 8'h80, 1'b0, 32'hFEDA_1234, 2'd1, 32'hFEDA_1234},  // R5 alias closed
        {8'h0A, 8'h00, 1'b1, 32'h000A_0010, 2'd0, 32'h000A_0010},  // R6 smm low
        {8'h0A, 8'h80, 1'b1, 32'hFEDA_0010, 2'd0, 32'h000A_0010},  // R6 smm high
        {8'h0A, 8'h80, 1'b1, 32'h000A_0010, 2'd1, 32'h000A_0010},  // R6 low hidden
        {8'h02, 8'h00, 1'b1, 32'h000A_0010, 2'd1, 32'h000A_0010},  // R6 global off
        {8'h0A, 8'h01, 1'b0, 32'h7FF0_0000, 2'd2, 32'h7FF0_0000},  // R8 sink
        {8'h0A, 8'h01, 1'b1, 32'h7FF0_0000, 2'd0, 32'h7FF0_0000},  // R8 smm dram
        {8'h0A, 8'h01, 1'b0, 32'h7FEF_FFFC, 2'd0, 32'h7FEF_FFFC},  // R8 below base
        {8'h02, 8'h01, 1'b0, 32'h7FF0_0000, 2'd0, 32'h7FF0_0000},  // R7 needs global
        {8'h0A, 8'h05, 1'b0, 32'h7F80_0000, 2'd2, 32'h7F80_0000},  // R7 8 MiB
        {8'h0A, 8'h07, 1'b0, 32'h7F00_0000, 2'd2, 32'h7F00_0000},  // R7 extended
        {8'h0A, 8'h03, 1'b0, 32'h7FE0_0000, 2'd2, 32'h7FE0_0000},  // R7 2 MiB
        {8'h02, 8'h00, 1'b0, 32'h8000_0000, 2'd1, 32'h8000_0000},  // R11 above
        {8'h02, 8'h00, 1'b0, 32'h0010_0000, 2'd0, 32'h0010_0000}   // R11 below
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [15:0] d);
        cfg_raddr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic access(input logic smm, input logic [31:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_smm = smm; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        do_reset();

        // R1 reset state
        cfg_read(2'd0, rd); check("R1 main ctl", 32'(rd), 32'h02);
        cfg_read(2'd1, rd); check("R1 ext ctl", 32'(rd), 32'h00);
        cfg_read(2'd2, rd); check("R1 ext size", 32'(rd), 32'hFFFF);
        check("R1 views", {27'd0, legacy_ram_open, high_alias_open, smm_low_en,
              smm_high_en, tseg_active}, 32'd0);
        check("R1 tseg_mb", 32'(tseg_mb), 32'd0);
        check("R1 tseg_base", tseg_base, 32'h8000_0000);

        // vector table: routes, remap, sink data, latency
        for (int i = 0; i < NV; i++) begin
            cfg_write(2'd0, 2'b01, {8'h00, VEC[i][82:75]});
            cfg_write(2'd1, 2'b01, {8'h00, VEC[i][74:67]});
            access(VEC[i][66], VEC[i][65:34]);
            check("R10 rsp_valid", 32'(rsp_valid), 32'd1);
            check("R4-R8,R11 route", 32'(rsp_route), 32'(VEC[i][33:32]));
            check("R5 rsp_addr", rsp_addr, VEC[i][31:0]);
            check("R8/R11 rdata", rsp_rdata, (VEC[i][33:32] == 2'd2) ? 32'hFFFF_FFFF : 32'h0);
            @(negedge clk);
            check("R10 single pulse", 32'(rsp_valid), 32'd0);
        end

        // R7 size and R8 base outputs
        cfg_write(2'd0, 2'b01, 16'h000A);
        cfg_write(2'd1, 2'b01, 16'h0005);
        check("R7 tseg_mb 8", 32'(tseg_mb), 32'd8);
        check("R8 base 8", tseg_base, 32'h7F80_0000);
        cfg_write(2'd1, 2'b01, 16'h0007);
        check("R7 tseg_mb ext", 32'(tseg_mb), 32'd16);
        check("R8 base ext", tseg_base, 32'h7F00_0000);

        // R9 extended size handshake
        cfg_write(2'd2, 2'b11, 16'h1234);
        cfg_read(2'd2, rd); check("R9 plain write", 32'(rd), 32'h1234);
        cfg_write(2'd2, 2'b01, 16'h00AB);
        cfg_read(2'd2, rd); check("R9 byte lane", 32'(rd), 32'h12AB);
        cfg_write(2'd2, 2'b11, 16'hFFFF);
        cfg_read(2'd2, rd); check("R9 query", 32'(rd), 32'h0010);

        // R2 / R3 lock
        cfg_write(2'd1, 2'b01, 16'h0001);
        cfg_write(2'd0, 2'b01, 16'h004A);
        cfg_read(2'd0, rd); check("R2 open set", 32'(rd), 32'h4A);
        check("R4 open view", 32'(legacy_ram_open), 32'd1);
        cfg_write(2'd0, 2'b01, 16'h005A);
        cfg_read(2'd0, rd); check("R2 lock clears open", 32'(rd), 32'h1A);
        check("R2 view closed", 32'(legacy_ram_open), 32'd0);
        cfg_write(2'd0, 2'b01, 16'h0062);
        cfg_read(2'd0, rd); check("R3 post-lock mask", 32'(rd), 32'h3A);
        cfg_write(2'd1, 2'b01, 16'h0080);
        cfg_read(2'd1, rd); check("R3 ext frozen", 32'(rd), 32'h01);
        check("R3 tseg kept", 32'(tseg_active), 32'd1);

        do_reset();
        cfg_read(2'd0, rd); check("R1 reset unlocks", 32'(rd), 32'h02);
        cfg_write(2'd0, 2'b01, 16'h00FF);
        cfg_read(2'd0, rd); check("R2 all ones", 32'(rd), 32'h3A);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule